// File: doc/BRIEF.md
# Amplifier Setting Source Arbiter

This block chooses the effective value of every setting a two-channel digital-input amplifier uses. Each setting can come from a strap pin or from a register written by the host. When reset is released the block samples the two serial-bus lines. If both lines are low it selects a pins-only mode. In any other case it selects a combined mode, in which a host register applies only while its group of strap pins is all low. In pins-only mode the straps decide every setting, and the modulation options are fixed.

The block also applies three overrides to each channel: the global enable, the soft mute and the per-channel output stop. For each channel it gives a gain code and a gain level in half-dB steps, plus two flags: whether audio is audible and whether the output stage drives. All effective fields come from one register bank, so they change together on a single clock edge.

Top module: `amp_cfg_arbiter`

## Requirements
- R1: `pin_only_mode` is 1 after reset release if `bus_scl` and `bus_sda` were both low on the last clock edge while `rst_n` was low. Otherwise it is 0, which selects combined mode.
- R2: Once reset is released, the latched mode does not change, whatever happens on `bus_scl` and `bus_sda`, until `rst_n` goes low again.
- R3: Format code values: 0 is I2S, 1 is left-justified, 2 is right-justified LSB-first, and 3 to 6 are right-justified MSB-first at 24, 20, 18 and 16 bits. In combined mode, straps at 0 select `cfg_fmt`; any other strap value is used directly. In pins-only mode the strap value is always used, and 0 means I2S.
- R4: Clock-ratio code values: 0 is 256fs, 1 is 384fs, 2 is 512fs and 3 is 768fs. A high `strap_mclk` gives code 2. A low strap gives `cfg_mclk` in combined mode and code 0 in pins-only mode.
- R5: Sample-rate code values: 0 is 32 kHz, 1 is 44.1/48 kHz, 2 is 88.2/96 kHz and 3 is 176.4/192 kHz. A high `strap_rate` gives code 2. A low strap gives `cfg_rate` in combined mode and code 1 in pins-only mode.
- R6: A nonzero `strap_gain` sets both channels' gain code to that value. If the straps are all zero, each channel takes its own `cfg_gain_*` in combined mode, and code 0 in pins-only mode.
- R7: For a gain code n ≥ 1, `eff_level_*` equals 3n − 165 in units of 0.5 dB. Code 55 is 0 dB and code 1 is −81 dB. Code 0 means mute: the level is −512 and the channel is not audible.
- R8: A high `strap_unmute` unmutes both channels. If it is low, each channel follows its own `cfg_unmute_*` (1 = audio) in combined mode and is muted in pins-only mode. `eff_audio_*` is 1 only when the channel is unmuted, its gain code is nonzero and `sys_en` is high.
- R9: While `sys_en` is low, both `eff_audio_*` and both `eff_drive_*` outputs are 0, whatever the gain and mute settings.
- R10: In combined mode, `cfg_stop_*` = 1 forces that channel's `eff_drive_*` to 0. Otherwise drive equals `sys_en`. In pins-only mode the stop bits have no effect.
- R11: In pins-only mode, `eff_idle50` = 1, `eff_midx` = 0 (87.5 %) and `eff_nsord` = 1 (seventh order). In combined mode these outputs copy `cfg_idle50`, `cfg_midx` and `cfg_nsord`.
- R12: Every effective output reflects the inputs sampled at the previous rising clock edge. While `rst_n` is low the outputs hold these values: format 0, clock ratio 0, rate 1, gains 0, levels −512, audio and drive 0, idle50 1, midx 0, nsord 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; its release latches the mode |
| sys_en | input | 1 | Global enable |
| bus_scl | input | 1 | Serial-bus clock line level |
| bus_sda | input | 1 | Serial-bus data line level |
| strap_fmt | input | 3 | Format straps |
| strap_mclk | input | 1 | Clock-ratio strap |
| strap_rate | input | 1 | Sample-rate strap |
| strap_gain | input | 6 | Common gain straps |
| strap_unmute | input | 1 | Common unmute strap (high = audio) |
| cfg_fmt | input | 3 | Register format |
| cfg_mclk | input | 2 | Register clock ratio |
| cfg_rate | input | 2 | Register sample rate |
| cfg_gain_l | input | 6 | Register gain, left |
| cfg_gain_r | input | 6 | Register gain, right |
| cfg_unmute_l | input | 1 | Register unmute, left |
| cfg_unmute_r | input | 1 | Register unmute, right |
| cfg_stop_l | input | 1 | Register output stop, left |
| cfg_stop_r | input | 1 | Register output stop, right |
| cfg_idle50 | input | 1 | Register 50 % idle pulse enable |
| cfg_midx | input | 1 | Register modulation index (1 = 100 %) |
| cfg_nsord | input | 1 | Register shaper order (1 = seventh) |
| pin_only_mode | output | 1 | Latched mode, 1 = pins only |
| eff_fmt | output | 3 | Effective format |
| eff_mclk | output | 2 | Effective clock ratio |
| eff_rate | output | 2 | Effective sample rate |
| eff_gain_l | output | 6 | Effective gain code, left |
| eff_gain_r | output | 6 | Effective gain code, right |
| eff_level_l | output | 10 | Signed gain level in 0.5 dB, left |
| eff_level_r | output | 10 | Signed gain level in 0.5 dB, right |
| eff_audio_l | output | 1 | Left channel audible |
| eff_audio_r | output | 1 | Right channel audible |
| eff_drive_l | output | 1 | Left output stage driving |
| eff_drive_r | output | 1 | Right output stage driving |
| eff_idle50 | output | 1 | Effective 50 % idle pulse |
| eff_midx | output | 1 | Effective modulation index |
| eff_nsord | output | 1 | Effective shaper order |

## Verification
The bench runs two full sweeps in each mode.

The first sweep covers every strap format against every register format, and both strap levels of the clock-ratio and rate pins against all four register codes. It shows whether a register value leaks through when a strap is set, and whether a pins-only default replaces a register value.

The second sweep runs all 64 gain codes, once as strap values and once as per-channel register values with the two channels mirrored. It combines them with every mute, enable and stop combination. This separates shared strap control from independent register control, checks the half-dB level arithmetic from −81 dB to +12 dB, and checks that enable low and code 0 both silence a channel.

Reset is released under all four bus-line patterns. The lines are then toggled to show that the mode stays latched.

// File: rtl/amp_cfg_pkg.sv
package amp_cfg_pkg;

    localparam int GAIN_W = 6;
    localparam int LVL_W  = GAIN_W + 4;
    localparam int FMT_W  = 3;
    localparam int NCH    = 2;

    typedef enum logic [1:0] {
        MCLK_256 = 2'd0,
        MCLK_384 = 2'd1,
        MCLK_512 = 2'd2,
        MCLK_768 = 2'd3
    } mclk_e;

    typedef enum logic [1:0] {
        RATE_32K  = 2'd0,
        RATE_48K  = 2'd1,
        RATE_96K  = 2'd2,
        RATE_192K = 2'd3
    } rate_e;

    typedef struct packed {
        logic [FMT_W-1:0] fmt;
        logic [1:0]       mclk;
        logic [1:0]       rate;
        logic             idle50;
        logic             midx;
        logic             nsord;
    } glob_cfg_t;

    typedef struct packed {
        logic [GAIN_W-1:0] gain;
        logic [LVL_W-1:0]  level;
        logic              audio;
        logic              drive;
    } chan_cfg_t;

    typedef struct packed {
        glob_cfg_t            g;
        chan_cfg_t [NCH-1:0]  ch;
    } eff_cfg_t;

    localparam logic [LVL_W-1:0] LVL_MUTE = {1'b1, {(LVL_W-1){1'b0}}};

endpackage

// File: rtl/amp_cfg_mode.sv
module amp_cfg_mode (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic pin_only
);
    logic pin_only_d;
    logic pin_only_q;

    // Follow the bus lines while in reset; freeze on release.
    always_comb begin
        pin_only_d = pin_only_q;
        if (!rst_n) begin
            pin_only_d = !scl && !sda;
        end
    end

    always_ff @(posedge clk) begin
        pin_only_q <= pin_only_d;
    end

    assign pin_only = pin_only_q;

    assert_mode_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> pin_only_q == $past(!scl && !sda));

    assert_mode_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(pin_only_q));

endmodule

// File: rtl/amp_cfg_glob.sv
module amp_cfg_glob
    import amp_cfg_pkg::*;
(
    input  logic             pin_only,
    input  logic [FMT_W-1:0] strap_fmt,
    input  logic             strap_mclk,
    input  logic             strap_rate,
    input  logic [FMT_W-1:0] reg_fmt,
    input  logic [1:0]       reg_mclk,
    input  logic [1:0]       reg_rate,
    input  logic             reg_idle50,
    input  logic             reg_midx,
    input  logic             reg_nsord,
    output glob_cfg_t        cfg_o
);
    always_comb begin
        // Format: straps at zero hand over to the register in combined mode.
        if (!pin_only && (strap_fmt == '0)) begin
            cfg_o.fmt = reg_fmt;
        end else begin
            cfg_o.fmt = strap_fmt;
        end

        if (strap_mclk) begin
            cfg_o.mclk = MCLK_512;
        end else if (pin_only) begin
            cfg_o.mclk = MCLK_256;
        end else begin
            cfg_o.mclk = reg_mclk;
        end

        if (strap_rate) begin
            cfg_o.rate = RATE_96K;
        end else if (pin_only) begin
            cfg_o.rate = RATE_48K;
        end else begin
            cfg_o.rate = reg_rate;
        end

        // Modulation options are fixed without a host.
        cfg_o.idle50 = pin_only ? 1'b1 : reg_idle50;
        cfg_o.midx   = pin_only ? 1'b0 : reg_midx;
        cfg_o.nsord  = pin_only ? 1'b1 : reg_nsord;
    end

endmodule

// File: rtl/amp_cfg_chan.sv
module amp_cfg_chan
    import amp_cfg_pkg::*;
(
    input  logic              pin_only,
    input  logic              en,
    input  logic [GAIN_W-1:0] strap_gain,
    input  logic              strap_unmute,
    input  logic [GAIN_W-1:0] reg_gain,
    input  logic              reg_unmute,
    input  logic              reg_stop,
    output chan_cfg_t         cfg_o
);
    localparam int MAX_CODE = (1 << GAIN_W) - 1;
    localparam int LVL_OFS  = 3 * MAX_CODE - 24;

    logic [GAIN_W-1:0] gain_sel;
    logic              unmute_sel;
    int                lvl_int;

    always_comb begin
        if (strap_gain != '0) begin
            gain_sel = strap_gain;
        end else if (pin_only) begin
            gain_sel = '0;
        end else begin
            gain_sel = reg_gain;
        end

        if (strap_unmute) begin
            unmute_sel = 1'b1;
        end else if (pin_only) begin
            unmute_sel = 1'b0;
        end else begin
            unmute_sel = reg_unmute;
        end

        lvl_int = 3 * int'(gain_sel) - LVL_OFS;

        cfg_o.gain  = gain_sel;
        cfg_o.level = (gain_sel == '0) ? LVL_MUTE : lvl_int[LVL_W-1:0];
        cfg_o.audio = en && unmute_sel && (gain_sel != '0);
        cfg_o.drive = en && (pin_only || !reg_stop);
    end

endmodule

// File: rtl/amp_cfg_arbiter.sv
module amp_cfg_arbiter
    import amp_cfg_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sys_en,
    input  logic                    bus_scl,
    input  logic                    bus_sda,
    input  logic [FMT_W-1:0]        strap_fmt,
    input  logic                    strap_mclk,
    input  logic                    strap_rate,
    input  logic [GAIN_W-1:0]       strap_gain,
    input  logic                    strap_unmute,
    input  logic [FMT_W-1:0]        cfg_fmt,
    input  logic [1:0]              cfg_mclk,
    input  logic [1:0]              cfg_rate,
    input  logic [GAIN_W-1:0]       cfg_gain_l,
    input  logic [GAIN_W-1:0]       cfg_gain_r,
    input  logic                    cfg_unmute_l,
    input  logic                    cfg_unmute_r,
    input  logic                    cfg_stop_l,
    input  logic                    cfg_stop_r,
    input  logic                    cfg_idle50,
    input  logic                    cfg_midx,
    input  logic                    cfg_nsord,
    output logic                    pin_only_mode,
    output logic [FMT_W-1:0]        eff_fmt,
    output logic [1:0]              eff_mclk,
    output logic [1:0]              eff_rate,
    output logic [GAIN_W-1:0]       eff_gain_l,
    output logic [GAIN_W-1:0]       eff_gain_r,
    output logic signed [LVL_W-1:0] eff_level_l,
    output logic signed [LVL_W-1:0] eff_level_r,
    output logic                    eff_audio_l,
    output logic                    eff_audio_r,
    output logic                    eff_drive_l,
    output logic                    eff_drive_r,
    output logic                    eff_idle50,
    output logic                    eff_midx,
    output logic                    eff_nsord
);
    localparam eff_cfg_t RESET_CFG = '{
        g:  '{fmt: '0, mclk: MCLK_256, rate: RATE_48K, idle50: 1'b1, midx: 1'b0, nsord: 1'b0},
        ch: {NCH{chan_cfg_t'{gain: '0, level: LVL_MUTE, audio: 1'b0, drive: 1'b0}}}
    };

    logic               pin_only;
    glob_cfg_t          glob_nx;
    chan_cfg_t          chan_nx   [NCH];
    logic [GAIN_W-1:0]  reg_gain  [NCH];
    logic [NCH-1:0]     reg_unmute;
    logic [NCH-1:0]     reg_stop;
    eff_cfg_t           cfg_d;
    eff_cfg_t           cfg_q;

    assign reg_gain[0] = cfg_gain_l;
    assign reg_gain[1] = cfg_gain_r;
    assign reg_unmute  = {cfg_unmute_r, cfg_unmute_l};
    assign reg_stop    = {cfg_stop_r, cfg_stop_l};

    amp_cfg_mode u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl      (bus_scl),
        .sda      (bus_sda),
        .pin_only (pin_only)
    );

    amp_cfg_glob u_glob (
        .pin_only   (pin_only),
        .strap_fmt  (strap_fmt),
        .strap_mclk (strap_mclk),
        .strap_rate (strap_rate),
        .reg_fmt    (cfg_fmt),
        .reg_mclk   (cfg_mclk),
        .reg_rate   (cfg_rate),
        .reg_idle50 (cfg_idle50),
        .reg_midx   (cfg_midx),
        .reg_nsord  (cfg_nsord),
        .cfg_o      (glob_nx)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        amp_cfg_chan u_chan (
            .pin_only     (pin_only),
            .en           (sys_en),
            .strap_gain   (strap_gain),
            .strap_unmute (strap_unmute),
            .reg_gain     (reg_gain[c]),
            .reg_unmute   (reg_unmute[c]),
            .reg_stop     (reg_stop[c]),
            .cfg_o        (chan_nx[c])
        );
    end

    always_comb begin
        cfg_d.g = glob_nx;
        for (int c = 0; c < NCH; c++) begin
            cfg_d.ch[c] = chan_nx[c];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= RESET_CFG;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign pin_only_mode = pin_only;
    assign eff_fmt       = cfg_q.g.fmt;
    assign eff_mclk      = cfg_q.g.mclk;
    assign eff_rate      = cfg_q.g.rate;
    assign eff_idle50    = cfg_q.g.idle50;
    assign eff_midx      = cfg_q.g.midx;
    assign eff_nsord     = cfg_q.g.nsord;
    assign eff_gain_l    = cfg_q.ch[0].gain;
    assign eff_gain_r    = cfg_q.ch[1].gain;
    assign eff_level_l   = $signed(cfg_q.ch[0].level);
    assign eff_level_r   = $signed(cfg_q.ch[1].level);
    assign eff_audio_l   = cfg_q.ch[0].audio;
    assign eff_audio_r   = cfg_q.ch[1].audio;
    assign eff_drive_l   = cfg_q.ch[0].drive;
    assign eff_drive_r   = cfg_q.ch[1].drive;

    assert_disable_silences_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(sys_en) |->
            !eff_audio_l && !eff_audio_r && !eff_drive_l && !eff_drive_r);

    assert_strap_gain_shared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && ($past(strap_gain) != '0) |->
            (eff_gain_l == $past(strap_gain)) && (eff_gain_r == $past(strap_gain)));

    assert_stop_halts_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !pin_only_mode && $past(cfg_stop_l) |-> !eff_drive_l);

    assert_pin_only_fixed_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && pin_only_mode |-> eff_idle50 && !eff_midx && eff_nsord);

    assert_code_zero_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_gain_r == '0) |-> !eff_audio_r && (eff_level_r == $signed(LVL_MUTE)));

endmodule

// File: tb/test_amp_cfg_arbiter.sv
`timescale 1ns/1ps
module test_amp_cfg_arbiter;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sys_en = 1'b0, bus_scl = 1'b1, bus_sda = 1'b1;
    logic [2:0] strap_fmt = '0, cfg_fmt = '0;
    logic strap_mclk = 0, strap_rate = 0, strap_unmute = 0;
    logic [5:0] strap_gain = '0, cfg_gain_l = '0, cfg_gain_r = '0;
    logic [1:0] cfg_mclk = '0, cfg_rate = '0;
    logic cfg_unmute_l = 0, cfg_unmute_r = 0, cfg_stop_l = 0, cfg_stop_r = 0;
    logic cfg_idle50 = 0, cfg_midx = 0, cfg_nsord = 0;

    logic pin_only_mode;
    logic [2:0] eff_fmt;
    logic [1:0] eff_mclk, eff_rate;
    logic [5:0] eff_gain_l, eff_gain_r;
    logic signed [9:0] eff_level_l, eff_level_r;
    logic eff_audio_l, eff_audio_r, eff_drive_l, eff_drive_r;
    logic eff_idle50, eff_midx, eff_nsord;

    int n_checks = 0;
    int n_fail = 0;
    bit po = 0;

    always #2.5 clk = ~clk;

    amp_cfg_arbiter i_amp_cfg_arbiter (.*);

    task automatic chk(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // R12 reset values
    task automatic check_reset_values();
        chk("R12", "fmt", eff_fmt, 0);
        chk("R12", "mclk", eff_mclk, 0);
        chk("R12", "rate", eff_rate, 1);
        chk("R12", "gain_l", eff_gain_l, 0);
        chk("R12", "level_r", int'(eff_level_r), -512);
        chk("R12", "audio/drive", {eff_audio_l, eff_audio_r, eff_drive_l, eff_drive_r}, 0);
        chk("R12", "misc", {eff_idle50, eff_midx, eff_nsord}, 3'b100);
    endtask

    task automatic do_reset(bit scl, bit sda);
        @(negedge clk);
        rst_n = 1'b0;
        bus_scl = scl;
        bus_sda = sda;
        repeat (3) @(negedge clk);
        check_reset_values();
        rst_n = 1'b1;
        @(negedge clk);
        po = !scl && !sda;
        chk("R1", "mode", pin_only_mode, int'(po));
        bus_scl = !scl;
        bus_sda = !sda;
        repeat (2) @(negedge clk);
        chk("R2", "mode after bus toggle", pin_only_mode, int'(po));
        bus_scl = 1'b0;
        bus_sda = 1'b0;
        @(negedge clk);
        chk("R2", "mode after bus low", pin_only_mode, int'(po));
    endtask

    // Inputs were applied on the previous negedge; the design registered them at the posedge between.
    task automatic check_vector();
        int g_l, g_r, u_l, u_r;
        chk("R3", "fmt", eff_fmt, (!po && strap_fmt == 0) ? cfg_fmt : strap_fmt);
        chk("R4", "mclk", eff_mclk, strap_mclk ? 2 : (po ? 0 : cfg_mclk));
        chk("R5", "rate", eff_rate, strap_rate ? 2 : (po ? 1 : cfg_rate));
        g_l = (strap_gain != 0) ? strap_gain : (po ? 0 : cfg_gain_l);
        g_r = (strap_gain != 0) ? strap_gain : (po ? 0 : cfg_gain_r);
        chk("R6", "gain_l", eff_gain_l, g_l);
        chk("R6", "gain_r", eff_gain_r, g_r);
        chk("R7", "level_l", int'(eff_level_l), (g_l == 0) ? -512 : 3 * g_l - 165);
        chk("R7", "level_r", int'(eff_level_r), (g_r == 0) ? -512 : 3 * g_r - 165);
        u_l = strap_unmute ? 1 : (po ? 0 : cfg_unmute_l);
        u_r = strap_unmute ? 1 : (po ? 0 : cfg_unmute_r);
        chk(sys_en ? "R8" : "R9", "audio_l", eff_audio_l, int'(sys_en && u_l != 0 && g_l != 0));
        chk(sys_en ? "R8" : "R9", "audio_r", eff_audio_r, int'(sys_en && u_r != 0 && g_r != 0));
        chk(sys_en ? "R10" : "R9", "drive_l", eff_drive_l, int'(sys_en && (po || !cfg_stop_l)));
        chk(sys_en ? "R10" : "R9", "drive_r", eff_drive_r, int'(sys_en && (po || !cfg_stop_r)));
        chk("R11", "idle50", eff_idle50, po ? 1 : cfg_idle50);
        chk("R11", "midx", eff_midx, po ? 0 : cfg_midx);
        chk("R11", "nsord", eff_nsord, po ? 1 : cfg_nsord);
    endtask

    task automatic sweep_global();
        for (int f = 0; f < 8; f++)
            for (int rf = 0; rf < 8; rf++)
                for (int k = 0; k < 64; k++) begin
                    strap_fmt  = f[2:0];
                    cfg_fmt    = rf[2:0];
                    strap_mclk = k[0];
                    cfg_mclk   = k[2:1];
                    strap_rate = k[3];
                    cfg_rate   = k[5:4];
                    cfg_idle50 = k[1] ^ f[0];
                    cfg_midx   = k[4] ^ rf[1];
                    cfg_nsord  = rf[0];
                    @(negedge clk);
                    check_vector();
                end
    endtask

    task automatic sweep_channels();
        for (int g = 0; g < 64; g++)
            for (int c = 0; c < 64; c++) begin
                strap_gain   = c[0] ? g[5:0] : 6'd0;
                cfg_gain_l   = g[5:0];
                cfg_gain_r   = 6'(63 - g);
                strap_unmute = c[1];
                cfg_unmute_l = c[2];
                cfg_unmute_r = c[3];
                sys_en       = c[4];
                cfg_stop_l   = c[5];
                cfg_stop_r   = c[5] ^ c[2];
                @(negedge clk);
                check_vector();
            end
    endtask

    initial begin
        // Pins-only mode
        do_reset(1'b0, 1'b0);
        sweep_global();
        sweep_channels();
        // Combined mode, each non-zero bus pattern
        do_reset(1'b1, 1'b0);
        do_reset(1'b0, 1'b1);
        do_reset(1'b1, 1'b1);
        sweep_global();
        sweep_channels();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule